// File: doc/BRIEF.md
# Sub-second real-time counter with compare alarms

This peripheral keeps time in a slow always-on clock domain (nominally a 32768 Hz crystal). A programmable divider makes a tick at `f_clk / (2*(DIV+1))`. Each tick advances a 32-bit counter. With DIV = 1023 the tick rate is 16 Hz, so the low four bits of the counter hold sixteenths of a second and the upper 28 bits hold whole seconds. The counter wraps after about 8.5 years. Software extends the count beyond 32 bits by keeping a wrap count in a scratch word that holds its value until reset.

Two compare registers raise sticky alarm flags. A third sticky flag marks each whole-second boundary. The flags sit in one status word, and each flag has its own enable bit. A flag is cleared by writing 1 to it. The level interrupt is high while any flag is set together with its enable. A clock-select register starts and stops the divider. All registers are reached through a simple 32-bit port with a write strobe and a combinational read.

Top module: `rtc_core`

## Requirements
- R1: After reset every register (counter 0x00, alarm0 0x04, status 0x08, divider 0x0C, alarm1 0x18, clock select 0x1C, scratch 0x40) reads 0 and `irq` is low.
- R2: While clock select holds 3, the counter advances by one every 2*(DIV+1) clock cycles, where DIV is the divider value.
- R3: A write to 0x00 loads the counter, and counting continues from the loaded value. If the write lands on a tick cycle, the write wins, and that tick raises no event.
- R4: With any clock-select value other than 3, the divider stays idle and the counter holds its value.
- R5: Status bit 0 (alarm0 at 0x04) and status bit 4 (alarm1 at 0x18) set when a tick brings the counter to the alarm value. Each flag stays set until it is cleared.
- R6: Writing 1 to an event bit (status bit 0, 1 or 4) clears it, and writing 0 leaves it unchanged. When a hardware set and a clear land in the same cycle, the set wins.
- R7: Status bit 1 sets on a tick that takes counter[3:0] from 15 to 0.
- R8: Status bits 2, 3 and 6 are the enables for bits 0, 1 and 4. A status write loads them directly from the written data. `irq` is the OR of each event flag ANDed with its enable. Status bits 5 and 7..31 read 0.
- R9: The scratch word at 0x40 reads back what was written. The divider reads back its 16 bits and clock select its 2 bits. Writes to any other offset are ignored, and reads from those offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on timekeeping clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 8 | Byte offset of the register accessed |
| wrEn | input | 1 | Write strobe, sampled at the rising edge |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `regAddr` |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that `wrEn`, `regAddr` and `wrData` are stable around each rising edge and settle between edges. The bench therefore drives them only at falling edges and holds each write for exactly one cycle.

The step and hold properties assume that the counter changes only through a tick or a counter write. The bench starts each scenario with the clock stopped, so every preset is loaded without a tick racing it.

Collisions between a tick and a write are created on purpose. The bench finds a tick edge by watching the counter change, then places the write two edges later, which is the next tick at DIV = 0.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int CNT_W = 32;
  localparam int SUB_W = 4;
  localparam int NUM_AL = 2;

  localparam logic [7:0] OFF_CNT  = 8'h00;
  localparam logic [7:0] OFF_AL0  = 8'h04;
  localparam logic [7:0] OFF_STAT = 8'h08;
  localparam logic [7:0] OFF_DIV  = 8'h0C;
  localparam logic [7:0] OFF_AL1  = 8'h18;
  localparam logic [7:0] OFF_CLK  = 8'h1C;
  localparam logic [7:0] OFF_SCR  = 8'h40;

  typedef enum logic [2:0] {
    RD_NONE, RD_CNT, RD_AL0, RD_STAT, RD_DIV, RD_AL1, RD_CLK, RD_SCR
  } rd_sel_e;

  typedef struct packed {
    logic          wrCnt;
    logic [NUM_AL-1:0] wrAl;
    logic          wrStat;
    logic          wrDiv;
    logic          wrClk;
    logic          wrScr;
    rd_sel_e       rdSel;
  } rtc_strobe_t;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  output rtc_strobe_t       stb
);
  logic [7:0] offs;
  assign offs = 8'(regAddr);

  always_comb begin
    stb = '0;
    stb.rdSel = RD_NONE;
    case (offs)
      OFF_CNT:  begin stb.wrCnt   = wrEn; stb.rdSel = RD_CNT;  end
      OFF_AL0:  begin stb.wrAl[0] = wrEn; stb.rdSel = RD_AL0;  end
      OFF_STAT: begin stb.wrStat  = wrEn; stb.rdSel = RD_STAT; end
      OFF_DIV:  begin stb.wrDiv   = wrEn; stb.rdSel = RD_DIV;  end
      OFF_AL1:  begin stb.wrAl[1] = wrEn; stb.rdSel = RD_AL1;  end
      OFF_CLK:  begin stb.wrClk   = wrEn; stb.rdSel = RD_CLK;  end
      OFF_SCR:  begin stb.wrScr   = wrEn; stb.rdSel = RD_SCR;  end
      default:  ;
    endcase
  end
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int CLK_SEL_W = 2,
  parameter int CLK_RUN   = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rtc_strobe_t          stb,
  input  logic [CNT_W-1:0]     wrData,
  output logic [CNT_W-1:0]     rdData,
  output logic                 irq,
  output logic                 tick,
  output logic [CNT_W-1:0]     cntQ,
  output logic [CNT_W-1:0]     statusQ,
  output logic [CLK_SEL_W-1:0] clkSelQ,
  output logic [CNT_W-1:0]     scratchQ
);
  localparam int EV_BIT[NUM_AL] = '{0, 4};
  localparam int EN_BIT[NUM_AL] = '{2, 6};
  localparam int HZ_EV_BIT = 1;
  localparam int HZ_EN_BIT = 3;

  logic [DIV_W-1:0] divQ, preCnt;
  logic             phase, run, tickUsed;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] alarmQ [NUM_AL];
  logic [NUM_AL-1:0] evAl, enAl;
  logic             evHz, enHz;

  assign run      = (clkSelQ == CLK_SEL_W'(CLK_RUN));
  assign tick     = run && phase && (preCnt >= divQ);
  assign tickUsed = tick && !stb.wrCnt;
  assign cntNext  = cntQ + CNT_W'(1);

  // prescaler: two half periods of DIV+1 cycles each
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      phase  <= 1'b0;
    end else if (!run) begin
      preCnt <= '0;
      phase  <= 1'b0;
    end else if (preCnt >= divQ) begin
      preCnt <= '0;
      phase  <= ~phase;
    end else begin
      preCnt <= preCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ     <= '0;
      divQ     <= '0;
      clkSelQ  <= '0;
      scratchQ <= '0;
    end else begin
      if (stb.wrCnt)     cntQ <= wrData;
      else if (tick)     cntQ <= cntNext;
      if (stb.wrDiv)     divQ <= wrData[DIV_W-1:0];
      if (stb.wrClk)     clkSelQ <= wrData[CLK_SEL_W-1:0];
      if (stb.wrScr)     scratchQ <= wrData;
    end
  end

  // compare channels: each with its own value, sticky flag and enable
  for (genvar i = 0; i < NUM_AL; i++) begin : g_alarm
    logic hit;
    assign hit = tickUsed && (cntNext == alarmQ[i]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        alarmQ[i] <= '0;
        evAl[i]   <= 1'b0;
        enAl[i]   <= 1'b0;
      end else begin
        if (stb.wrAl[i]) alarmQ[i] <= wrData;
        if (hit)         evAl[i] <= 1'b1;
        else if (stb.wrStat && wrData[EV_BIT[i]]) evAl[i] <= 1'b0;
        if (stb.wrStat)  enAl[i] <= wrData[EN_BIT[i]];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evHz <= 1'b0;
      enHz <= 1'b0;
    end else begin
      if (tickUsed && (cntQ[SUB_W-1:0] == {SUB_W{1'b1}})) evHz <= 1'b1;
      else if (stb.wrStat && wrData[HZ_EV_BIT]) evHz <= 1'b0;
      if (stb.wrStat) enHz <= wrData[HZ_EN_BIT];
    end
  end

  assign statusQ = {25'b0, enAl[1], 1'b0, evAl[1], enHz, enAl[0], evHz, evAl[0]};
  assign irq     = (|(evAl & enAl)) | (evHz & enHz);

  always_comb begin
    case (stb.rdSel)
      RD_CNT:  rdData = cntQ;
      RD_AL0:  rdData = alarmQ[0];
      RD_STAT: rdData = statusQ;
      RD_DIV:  rdData = CNT_W'(divQ);
      RD_AL1:  rdData = alarmQ[1];
      RD_CLK:  rdData = CNT_W'(clkSelQ);
      RD_SCR:  rdData = scratchQ;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DIV_W     = 16,
  parameter int CLK_SEL_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              irq
);
  rtc_strobe_t          stb;
  logic                 tick;
  logic [CNT_W-1:0]     cntQ, statusQ, scratchQ;
  logic [CLK_SEL_W-1:0] clkSelQ;

  rtc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr(regAddr), .wrEn(wrEn), .stb(stb)
  );

  rtc_datapath #(.DIV_W(DIV_W), .CLK_SEL_W(CLK_SEL_W), .CLK_RUN(3)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .rdData(rdData),
    .irq(irq), .tick(tick), .cntQ(cntQ), .statusQ(statusQ),
    .clkSelQ(clkSelQ), .scratchQ(scratchQ)
  );
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk #(
  parameter int ADDR_W    = 8,
  parameter int CLK_SEL_W = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    regAddr,
  input logic                 wrEn,
  input logic                 wrBit0,
  input logic                 tick,
  input logic [31:0]          cntQ,
  input logic [CLK_SEL_W-1:0] clkSelQ,
  input logic [31:0]          scratchQ,
  input logic                 ev0,
  input logic                 evHz,
  input logic                 en0,
  input logic                 enHz,
  input logic                 ev1,
  input logic                 en1,
  input logic                 irq
);
  logic cntWr, statWr, scrWr;
  assign cntWr  = wrEn && (regAddr == ADDR_W'(8'h00));
  assign statWr = wrEn && (regAddr == ADDR_W'(8'h08));
  assign scrWr  = wrEn && (regAddr == ADDR_W'(8'h40));

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !cntWr) |=> (cntQ == $past(cntQ) + 32'd1));

  p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((clkSelQ != CLK_SEL_W'(3)) && !cntWr) |=> $stable(cntQ));

  p_no_tick_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (clkSelQ != CLK_SEL_W'(3)) |-> !tick);

  p_al0_on_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ev0) |-> $past(tick));

  p_al1_on_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ev1) |-> $past(tick));

  p_w1c_r6: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && wrBit0 && !tick) |=> !ev0);

  p_hz_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(evHz) |-> (cntQ[3:0] == 4'h0));

  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(en0 || enHz || en1) |-> !irq);

  p_scratch_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !scrWr |=> $stable(scratchQ));
endmodule

bind rtc_core rtc_core_chk #(.ADDR_W(ADDR_W), .CLK_SEL_W(CLK_SEL_W)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrBit0(wrData[0]),
  .tick(tick), .cntQ(cntQ), .clkSelQ(clkSelQ), .scratchQ(scratchQ),
  .ev0(statusQ[0]), .evHz(statusQ[1]), .en0(statusQ[2]), .enHz(statusQ[3]),
  .ev1(statusQ[4]), .en1(statusQ[6]), .irq(irq)
);

// File: tb/sim_rtc_core.sv
module sim_rtc_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int nChk = 0;
  int nBad = 0;

  rtc_core u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = rdData;
  endtask

  task automatic wait_cnt(input logic [31:0] v);
    logic [31:0] c;
    regAddr = 8'h00;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      #1 c = rdData;
      if (c == v) return;
    end
    check("wait_cnt timeout", c, v);
  endtask

  task automatic measure(output int cyc);
    logic [31:0] a, b;
    regAddr = 8'h00;
    @(negedge clk); #1 a = rdData;
    do begin @(negedge clk); #1 b = rdData; end while (b == a);
    a = b; cyc = 0;
    do begin @(negedge clk); cyc++; #1 b = rdData; end while (b == a && cyc < 1000);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    logic [7:0] offs [7] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h18, 8'h1C, 8'h40};
    foreach (offs[i]) begin
      rd(offs[i], d);
      check($sformatf("R1 reset reg %h", offs[i]), d, 32'h0);
    end
    check("R1 reset irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_prescale();
    int cyc;
    wr(8'h0C, 32'd0); wr(8'h1C, 32'd3);
    measure(cyc);
    check("R2 period DIV=0", cyc, 32'd2);
    wr(8'h0C, 32'd2);
    measure(cyc); measure(cyc);
    check("R2 period DIV=2", cyc, 32'd6);
    wr(8'h0C, 32'd0);
  endtask

  task automatic t_idle();
    logic [31:0] a, b;
    wr(8'h1C, 32'd2);
    rd(8'h00, a);
    repeat (20) @(negedge clk);
    rd(8'h00, b);
    check("R4 hold with select 2", b, a);
    wr(8'h1C, 32'd0);
    wr(8'h00, 32'h0000_1234);
    repeat (20) @(negedge clk);
    rd(8'h00, b);
    check("R4 hold with select 0", b, 32'h0000_1234);
  endtask

  task automatic t_load();
    logic [31:0] d;
    wr(8'h1C, 32'd0);
    wr(8'h08, 32'h0000_0013);
    wr(8'h00, 32'h0000_0020);
    wr(8'h1C, 32'd3);
    wait_cnt(32'h0000_002F);
    wr(8'h00, 32'h0000_0100);
    rd(8'h00, d);
    check("R3 write wins over tick", d, 32'h0000_0100);
    rd(8'h08, d);
    check("R3 suppressed tick raises no second event", d & 32'h2, 32'h0);
    wait_cnt(32'h0000_0101);
    rd(8'h00, d);
    check("R3 counts on from loaded value", d, 32'h0000_0101);
    wr(8'h1C, 32'd0);
  endtask

  task automatic t_alarm0();
    logic [31:0] d;
    wr(8'h00, 32'h10); wr(8'h04, 32'h14); wr(8'h08, 32'h17);
    rd(8'h08, d);
    check("R5 alarm0 clear before match", d & 32'h1, 32'h0);
    check("R8 irq low before match", {31'b0, irq}, 32'h0);
    wr(8'h1C, 32'd3);
    wait_cnt(32'h14);
    rd(8'h08, d);
    check("R5 alarm0 set on match", d & 32'h1, 32'h1);
    check("R8 irq with alarm0 enabled", {31'b0, irq}, 32'h1);
    wr(8'h08, 32'h04);
    rd(8'h08, d);
    check("R6 write 0 keeps alarm0", d & 32'h1, 32'h1);
    wr(8'h1C, 32'd0);
    wr(8'h08, 32'h05);
    rd(8'h08, d);
    check("R6 write 1 clears alarm0", d & 32'h5, 32'h4);
    check("R8 irq drops after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_alarm1();
    logic [31:0] d;
    wr(8'h00, 32'h30); wr(8'h18, 32'h33); wr(8'h08, 32'h13);
    wr(8'h1C, 32'd3);
    wait_cnt(32'h34);
    wr(8'h1C, 32'd0);
    rd(8'h08, d);
    check("R5 alarm1 sticky after match", d & 32'h10, 32'h10);
    check("R8 irq masked while alarm1 disabled", {31'b0, irq}, 32'h0);
    wr(8'h08, 32'h40);
    check("R8 irq once alarm1 enabled", {31'b0, irq}, 32'h1);
    wr(8'h08, 32'h50);
    rd(8'h08, d);
    check("R6 alarm1 cleared, enable kept", d, 32'h40);
    check("R8 irq after alarm1 clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_hz();
    logic [31:0] d;
    wr(8'h08, 32'h0A);
    wr(8'h00, 32'h0E);
    wr(8'h1C, 32'd3);
    wait_cnt(32'h0F);
    rd(8'h08, d);
    check("R7 no second event before wrap", d & 32'h2, 32'h0);
    wait_cnt(32'h10);
    rd(8'h08, d);
    check("R7 second event on 15 to 0", d & 32'h2, 32'h2);
    check("R8 irq from second event", {31'b0, irq}, 32'h1);
    wr(8'h1C, 32'd0);
    wr(8'h08, 32'h02);
  endtask

  task automatic t_setwins();
    logic [31:0] d;
    wr(8'h00, 32'h20); wr(8'h04, 32'h24); wr(8'h08, 32'h05);
    wr(8'h1C, 32'd3);
    wait_cnt(32'h23);
    wr(8'h08, 32'h05);
    rd(8'h08, d);
    check("R6 set wins over same-cycle clear", d & 32'h1, 32'h1);
    wr(8'h1C, 32'd0);
    wr(8'h08, 32'h01);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(8'h40, 32'hDEAD_BEEF);
    rd(8'h40, d);
    check("R9 scratch readback", d, 32'hDEAD_BEEF);
    wr(8'h0C, 32'hFFFF_03FF);
    rd(8'h0C, d);
    check("R9 divider readback", d, 32'h0000_03FF);
    wr(8'h1C, 32'hFFFF_FFFE);
    rd(8'h1C, d);
    check("R9 clock select readback", d, 32'h2);
    wr(8'h14, 32'h1234_5678);
    rd(8'h14, d);
    check("R9 unmapped offset reads 0", d, 32'h0);
    rd(8'h40, d);
    check("R9 unmapped write leaves scratch", d, 32'hDEAD_BEEF);
    wr(8'h1C, 32'd0);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d);
    check("R8 enables load, reserved bits 0", d, 32'h0000_004C);
    wr(8'h08, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_idle();
    t_load();
    t_alarm0();
    t_alarm1();
    t_hz();
    t_setwins();
    t_regs();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nChk++; nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule